// File: doc/BRIEF.md
# Paired-Register Wide ALU

This block is the execution unit of a small 8-bit controller core. It holds sixteen byte registers and adds two kinds of wide arithmetic: an unsigned 8x8 multiply with a 16-bit product, and 16-bit add and subtract on aligned register pairs. Borrow or carry can be chained from one wide operation into the next.

The register file is built from two byte-wide banks. Even-numbered registers sit in one bank and odd-numbered registers sit in the other. A write-steering layer in front of the banks lets one cycle update either a single byte or a whole pair. The surrounding core presents a decoded operation, two register indices, an immediate for loads and a write strobe. The result lands in the register file on the next rising clock edge. A separate read index returns any register at any time, and the carry and zero flags are output directly.

Operand A always names the destination. For wide operations its bit 0 is ignored, so operand A always selects the even register of a pair.

Top module: `wide_pair_alu`

## Requirements
- R1: While `rst_ni` is low, all sixteen registers and both flags read back as zero.
- R2: With `op_i`=0 (byte load) and `wr_en_i` high, `data_i[7:0]` is written to register `ra_i`. Bit 0 of `ra_i` selects the odd or even bank. The other register of the pair and both flags keep their values.
- R3: With `op_i`=1 (pair load), `data_i[7:0]` goes to register `ra_i&~1` and `data_i[15:8]` goes to register `(ra_i&~1)+1`, both in the same cycle. The flags keep their values.
- R4: With `op_i`=2 (multiply), registers `ra_i` and `rb_i` are multiplied as unsigned bytes, using any index for either operand. The low product byte goes to register `ra_i&~1` and the high product byte goes to the next register. Carry is cleared.
- R5: With `op_i`=3 (wide add), the pair at A becomes pair A + pair B. Carry takes bit 16 of the sum.
- R6: With `op_i`=4 (wide add with carry), the current carry flag is also added in as bit 0, and carry takes bit 16 of the result.
- R7: With `op_i`=5 (wide subtract), the pair at A becomes pair A - pair B modulo 2^16. Carry is set exactly when the minuend is smaller than the subtrahend.
- R8: With `op_i`=6 (wide subtract with borrow), the current carry flag is also subtracted. Carry is set when the minuend is smaller than the subtrahend plus the borrow-in.
- R9: After any multiply or wide add or subtract, zero is set exactly when the 16-bit result is zero.
- R10: For operations 2 to 6, bit 0 of the destination index is forced to 0. For operations 3 to 6, bit 0 of operand B is also forced to 0.
- R11: When `wr_en_i` is low, or when `op_i`=7, no register and no flag changes.
- R12: Results and flags change only on the rising edge of `clk_i`. `rd_data_o` follows `rd_idx_i` combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| op_i | input | 3 | Decoded operation code (0 to 7) |
| wr_en_i | input | 1 | Write strobe; the operation takes effect only when this is high |
| ra_i | input | 4 | Operand A and destination index |
| rb_i | input | 4 | Operand B index |
| data_i | input | 16 | Immediate for the byte and pair loads |
| rd_idx_i | input | 4 | Read-back register index |
| rd_data_o | output | 8 | Contents of register `rd_idx_i` |
| carry_o | output | 1 | Carry / borrow flag |
| zero_o | output | 1 | Zero flag |

## Verification
A wrong bank-select or steering decision shows up one clock after the write. Either the byte lands in the neighbour register of the pair, or the neighbour is corrupted, and a full readback through `rd_idx_i` after each operation exposes it. A bad carry chain or borrow polarity shows on `carry_o` in that same cycle. It also shows one operation later in the value of a carry-in variant. A misaligned pair index writes the wrong pair and is caught by the same readback. Operand values mix random data with boundary patterns: all-ones, zero results, exact wrap-around, and the worked examples 0xCA*0xFE and 0xBEEF+0xCAFE.

// File: rtl/wpa_pkg.sv
package wpa_pkg;
  typedef enum logic [2:0] {
    OP_LD8   = 3'd0,
    OP_LD16  = 3'd1,
    OP_MUL   = 3'd2,
    OP_ADDW  = 3'd3,
    OP_ADDWC = 3'd4,
    OP_SUBW  = 3'd5,
    OP_SUBWC = 3'd6,
    OP_NOP   = 3'd7
  } wpa_op_e;

  function automatic logic is_wide(input wpa_op_e op);
    return (op == OP_ADDW) || (op == OP_ADDWC) || (op == OP_SUBW) || (op == OP_SUBWC);
  endfunction

  function automatic logic is_sub(input wpa_op_e op);
    return (op == OP_SUBW) || (op == OP_SUBWC);
  endfunction

  function automatic logic uses_cin(input wpa_op_e op);
    return (op == OP_ADDWC) || (op == OP_SUBWC);
  endfunction
endpackage

// File: rtl/wpa_bank.sv
// One byte-wide bank of the register file: one write port, three read ports.
module wpa_bank #(
  parameter int DW    = 8,
  parameter int DEPTH = 8,
  localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_a_i,
  input  logic [AW-1:0] raddr_b_i,
  input  logic [AW-1:0] raddr_r_i,
  output logic [DW-1:0] rdata_a_o,
  output logic [DW-1:0] rdata_b_o,
  output logic [DW-1:0] rdata_r_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar e = 0; e < DEPTH; e++) begin : g_entry
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                             mem_q[e] <= '0;
      else if (we_i && (waddr_i == AW'(e)))    mem_q[e] <= wdata_i;
    end
  end

  assign rdata_a_o = mem_q[raddr_a_i];
  assign rdata_b_o = mem_q[raddr_b_i];
  assign rdata_r_o = mem_q[raddr_r_i];

  // R2/R3: a strobed write lands in the addressed entry
  a_r3_bank_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(waddr_i)] == $past(wdata_i));
endmodule

// File: rtl/wpa_mul.sv
module wpa_mul #(
  parameter int DW = 8
) (
  input  logic [DW-1:0]   a_i,
  input  logic [DW-1:0]   b_i,
  output logic [2*DW-1:0] prod_o
);
  assign prod_o = (2*DW)'(a_i) * (2*DW)'(b_i);

  always_comb begin
    if (a_i == '0 || b_i == '0)
      a_r4_zero_operand: assert (prod_o == '0);
  end
endmodule

// File: rtl/wpa_addsub.sv
module wpa_addsub #(
  parameter int W = 16
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  input  logic         cin_i,
  output logic [W-1:0] res_o,
  output logic         cout_o
);
  logic [W:0] ext;

  always_comb begin
    if (sub_i) ext = {1'b0, a_i} - {1'b0, b_i} - (W+1)'(cin_i);
    else       ext = {1'b0, a_i} + {1'b0, b_i} + (W+1)'(cin_i);
  end

  assign res_o  = ext[W-1:0];
  assign cout_o = ext[W];

  always_comb begin
    if (!sub_i && !cin_i)
      a_r5_wrap_is_carry: assert (cout_o == (res_o < a_i));
    if (sub_i && !cin_i)
      a_r7_borrow_when_smaller: assert (cout_o == (a_i < b_i));
  end
endmodule

// File: rtl/wide_pair_alu.sv
module wide_pair_alu
  import wpa_pkg::*;
#(
  parameter int DW   = 8,
  parameter int NREG = 16,
  localparam int PW    = 2 * DW,
  localparam int DEPTH = NREG / 2,
  localparam int IW    = $clog2(NREG),
  localparam int AW    = IW - 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [2:0]    op_i,
  input  logic          wr_en_i,
  input  logic [IW-1:0] ra_i,
  input  logic [IW-1:0] rb_i,
  input  logic [PW-1:0] data_i,
  input  logic [IW-1:0] rd_idx_i,
  output logic [DW-1:0] rd_data_o,
  output logic          carry_o,
  output logic          zero_o
);
  wpa_op_e op;
  assign op = wpa_op_e'(op_i);

  logic [AW-1:0] pair_a, pair_b, pair_r;
  assign pair_a = ra_i[IW-1:1];
  assign pair_b = rb_i[IW-1:1];
  assign pair_r = rd_idx_i[IW-1:1];

  // index 0 = even (low) bank, 1 = odd (high) bank
  logic          bank_we [2];
  logic [DW-1:0] bank_wd [2];
  logic [DW-1:0] rd_a    [2];
  logic [DW-1:0] rd_b    [2];
  logic [DW-1:0] rd_r    [2];

  for (genvar g = 0; g < 2; g++) begin : g_bank
    wpa_bank #(.DW(DW), .DEPTH(DEPTH)) i_bank (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .we_i      (bank_we[g]),
      .waddr_i   (pair_a),
      .wdata_i   (bank_wd[g]),
      .raddr_a_i (pair_a),
      .raddr_b_i (pair_b),
      .raddr_r_i (pair_r),
      .rdata_a_o (rd_a[g]),
      .rdata_b_o (rd_b[g]),
      .rdata_r_o (rd_r[g])
    );
  end

  logic [DW-1:0] byte_a, byte_b;
  logic [PW-1:0] wide_a, wide_b;
  assign byte_a = ra_i[0] ? rd_a[1] : rd_a[0];
  assign byte_b = rb_i[0] ? rd_b[1] : rd_b[0];
  assign wide_a = {rd_a[1], rd_a[0]};
  assign wide_b = {rd_b[1], rd_b[0]};
  assign rd_data_o = rd_idx_i[0] ? rd_r[1] : rd_r[0];

  logic [PW-1:0] prod;
  logic [PW-1:0] as_res;
  logic          as_cout;

  wpa_mul #(.DW(DW)) i_mul (
    .a_i    (byte_a),
    .b_i    (byte_b),
    .prod_o (prod)
  );

  wpa_addsub #(.W(PW)) i_addsub (
    .a_i    (wide_a),
    .b_i    (wide_b),
    .sub_i  (is_sub(op)),
    .cin_i  (uses_cin(op) & carry_o),
    .res_o  (as_res),
    .cout_o (as_cout)
  );

  logic          arith;
  logic [PW-1:0] arith_res;
  assign arith     = (op == OP_MUL) || is_wide(op);
  assign arith_res = (op == OP_MUL) ? prod : as_res;

  // write steering in front of the banks
  always_comb begin
    bank_we[0] = 1'b0;
    bank_we[1] = 1'b0;
    bank_wd[0] = data_i[DW-1:0];
    bank_wd[1] = data_i[DW-1:0];
    unique case (op)
      OP_LD8: begin
        if (ra_i[0]) bank_we[1] = wr_en_i;
        else         bank_we[0] = wr_en_i;
      end
      OP_LD16: begin
        bank_we[0] = wr_en_i;
        bank_we[1] = wr_en_i;
        bank_wd[1] = data_i[PW-1:DW];
      end
      OP_MUL, OP_ADDW, OP_ADDWC, OP_SUBW, OP_SUBWC: begin
        bank_we[0] = wr_en_i;
        bank_we[1] = wr_en_i;
        bank_wd[0] = arith_res[DW-1:0];
        bank_wd[1] = arith_res[PW-1:DW];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_o <= 1'b0;
      zero_o  <= 1'b0;
    end else if (wr_en_i && arith) begin
      carry_o <= (op == OP_MUL) ? 1'b0 : as_cout;
      zero_o  <= (arith_res == '0);
    end
  end

  a_r4_mul_clears_carry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && op == OP_MUL |=> !carry_o);

  // R2, R3: loads never touch the flags
  a_r2_load_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i && (op == OP_LD8 || op == OP_LD16) |=> $stable(carry_o) && $stable(zero_o));

  a_r11_idle_keeps_flags: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i || op == OP_NOP |=> $stable(carry_o) && $stable(zero_o));

  a_r10_single_bank_on_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_LD8 |-> !(bank_we[0] && bank_we[1]));
endmodule

// File: tb/test_wide_pair_alu.sv
module test_wide_pair_alu;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  op_i = 3'd7;
  logic        wr_en_i = 1'b0;
  logic [3:0]  ra_i = '0, rb_i = '0, rd_idx_i = '0;
  logic [15:0] data_i = '0;
  logic [7:0]  rd_data_o;
  logic        carry_o, zero_o;

  int n_chk = 0;
  int n_bad = 0;

  logic [7:0] mr [16];
  logic       mc, mz;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  wide_pair_alu i_wide_pair_alu (
    .clk_i, .rst_ni, .op_i, .wr_en_i, .ra_i, .rb_i, .data_i,
    .rd_idx_i, .rd_data_o, .carry_o, .zero_o
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    for (int i = 0; i < 16; i++) begin
      rd_idx_i = 4'(i);
      #1;
      chk(tag, 16'(rd_data_o), 16'(mr[i]));
    end
    chk({tag, " carry"}, 16'(carry_o), 16'(mc));
    chk({tag, " R9 zero"}, 16'(zero_o), 16'(mz));
  endtask

  function automatic string op_tag(input logic [2:0] op, input logic en);
    if (!en) return "R11";
    case (op)
      3'd0: return "R2";
      3'd1: return "R3";
      3'd2: return "R4";
      3'd3: return "R5";
      3'd4: return "R6";
      3'd5: return "R7";
      3'd6: return "R8";
      default: return "R11";
    endcase
  endfunction

  // reference model update, computed from the requirements
  task automatic model(input logic [2:0] op, input logic [3:0] a, input logic [3:0] b,
                       input logic [15:0] d, input logic en);
    logic [3:0]  ae, be;
    logic [15:0] pa, pb, r;
    logic [16:0] ext;
    if (!en) return;
    ae = a & 4'hE;
    be = b & 4'hE;
    pa = {mr[4'(ae + 1)], mr[ae]};
    pb = {mr[4'(be + 1)], mr[be]};
    case (op)
      3'd0: mr[a] = d[7:0];
      3'd1: begin mr[ae] = d[7:0]; mr[4'(ae + 1)] = d[15:8]; end
      3'd2: begin
        r = 16'(mr[a]) * 16'(mr[b]);
        mr[ae] = r[7:0]; mr[4'(ae + 1)] = r[15:8];
        mc = 1'b0; mz = (r == 0);
      end
      3'd3, 3'd4, 3'd5, 3'd6: begin
        if (op == 3'd3)      ext = {1'b0, pa} + {1'b0, pb};
        else if (op == 3'd4) ext = {1'b0, pa} + {1'b0, pb} + 17'(mc);
        else if (op == 3'd5) ext = {1'b0, pa} - {1'b0, pb};
        else                 ext = {1'b0, pa} - {1'b0, pb} - 17'(mc);
        mr[ae] = ext[7:0]; mr[4'(ae + 1)] = ext[15:8];
        mc = ext[16]; mz = (ext[15:0] == 0);
      end
      default: ;
    endcase
  endtask

  task automatic apply(input logic [2:0] op, input logic [3:0] a, input logic [3:0] b,
                       input logic [15:0] d, input logic en);
    @(negedge clk_i);
    op_i = op; ra_i = a; rb_i = b; data_i = d; wr_en_i = en;
    @(posedge clk_i);
    model(op, a, b, d, en);
    @(negedge clk_i);
    wr_en_i = 1'b0; op_i = 3'd7;
    compare_all(op_tag(op, en));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int i = 0; i < 16; i++) mr[i] = '0;
    mc = 1'b0; mz = 1'b0;
    repeat (3) @(negedge clk_i);
    compare_all("R1 reset");
    rst_ni = 1'b1;

    // R12: nothing changes before the edge
    @(negedge clk_i);
    op_i = 3'd0; ra_i = 4'd5; data_i = 16'h00AA; wr_en_i = 1'b1; rd_idx_i = 4'd5;
    #1 chk("R12 before edge", 16'(rd_data_o), 16'h0000);
    @(posedge clk_i); model(3'd0, 4'd5, 4'd0, 16'h00AA, 1'b1);
    @(negedge clk_i); wr_en_i = 1'b0; op_i = 3'd7;
    compare_all("R2 R12");

    // worked examples
    apply(3'd0, 4'd0, 4'd0, 16'h00CA, 1'b1);
    apply(3'd0, 4'd2, 4'd0, 16'h00FE, 1'b1);
    apply(3'd2, 4'd0, 4'd2, 16'h0000, 1'b1);   // R4: 0xCA*0xFE=0xC86C
    rd_idx_i = 4'd0; #1 chk("R4 lo", 16'(rd_data_o), 16'h006C);
    rd_idx_i = 4'd1; #1 chk("R4 hi", 16'(rd_data_o), 16'h00C8);
    apply(3'd1, 4'd0, 4'd0, 16'hCAFE, 1'b1);
    apply(3'd1, 4'd2, 4'd0, 16'hBEEF, 1'b1);
    apply(3'd3, 4'd2, 4'd0, 16'h0000, 1'b1);   // R5
    chk("R5 carry", 16'(carry_o), 16'h0001);
    rd_idx_i = 4'd3; #1 chk("R5 hi", 16'(rd_data_o), 16'h0089);
    apply(3'd4, 4'd2, 4'd0, 16'h0000, 1'b1);   // R6 carry-in used
    // R10: odd indices aligned
    apply(3'd5, 4'd3, 4'd1, 16'h0000, 1'b1);
    apply(3'd2, 4'd7, 4'd1, 16'h0000, 1'b1);
    // R7, R9: borrow and zero
    apply(3'd1, 4'd4, 4'd0, 16'h0000, 1'b1);
    apply(3'd1, 4'd6, 4'd0, 16'h0001, 1'b1);
    apply(3'd5, 4'd4, 4'd6, 16'h0000, 1'b1);
    chk("R7 borrow", 16'(carry_o), 16'h0001);
    apply(3'd6, 4'd4, 4'd4, 16'h0000, 1'b1);   // R8: x - x - 1
    apply(3'd1, 4'd8, 4'd0, 16'hFFFF, 1'b1);
    apply(3'd1, 4'd10, 4'd0, 16'h0001, 1'b1);
    apply(3'd3, 4'd8, 4'd10, 16'h0000, 1'b1);
    chk("R9 zero wrap", 16'(zero_o), 16'h0001);
    apply(3'd2, 4'd12, 4'd13, 16'h0000, 1'b1); // zero product
    // R11: strobe low and NOP
    apply(3'd1, 4'd0, 4'd0, 16'h5555, 1'b0);
    apply(3'd7, 4'd0, 4'd0, 16'h5555, 1'b1);

    for (int k = 0; k < 400; k++) begin
      logic [2:0]  op;
      logic [15:0] d;
      op = 3'($urandom % 8);
      d  = 16'($urandom);
      if (k % 37 == 0) d = 16'hFFFF;
      apply(op, 4'($urandom), 4'($urandom), d, ($urandom % 8) != 0);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule